// File: doc/BRIEF.md
# Four-Channel PWM Controller with Shadowed Period Loading

This block generates four independent pulse-width-modulated outputs from a small word-addressed register bank. Software writes a period and an active time for each channel, already converted to raw input-clock ticks. It also writes three shared bit vectors, each holding one bit per channel: polarity, run and output enable. A running channel counts from 0 up to period−1 and wraps. Its output sits at the active level while the count is below the active time and at the inactive level for the rest of the period.

Each channel keeps private shadow copies of its period and active time. The waveform ignores new programmed values until the channel is stopped and started again. While the run bit is clear, the shadows follow the programmed registers. Setting the run bit freezes them and starts the count at 0. When a channel's shadowed period and active time are both zero, the channel produces no waveform and its pin is held high.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset every register reads 0, every `pwm_oe_o` bit is 0 and every `pwm_o` bit is 1, because all channels start with zero period and zero active time.
- R2: Register map (byte addresses; only addresses with the two low bits at 0 are mapped):
  - channel n active time is at n×8, and its period is at n×8+4, both 32 bits;
  - polarity is at 0x40, run at 0x44 and output enable at 0xD0, with bit n belonging to channel n;
  - a write lands on the clock edge where `we_i` is high, and each register reads back its last written value;
  - bits above bit 3 of the three shared registers are not stored and read as 0.
- R3: Any unmapped address, including every unaligned address, reads as 0, and writes to unmapped addresses have no effect.
- R4: A run bit set at clock edge t gives count 0 in the cycle after t and count k mod P in the k-th cycle after that. With normal polarity (polarity bit 0), the output is 1 while the count is below A and 0 otherwise. P and A are the shadowed period and active time.
- R5: An active time A ≥ P, with A nonzero, gives a constant active level. A = 0 with P ≠ 0 gives a constant inactive level. P = 0 with A ≠ 0 counts as A ≥ P.
- R6: A polarity bit of 1 swaps the active and inactive levels. The change shows on `pwm_o` in the cycle after the write.
- R7: While a channel's run bit is 0, its counter is held at 0 and its output equals its polarity bit (the inactive level). The exception is the R8 case.
- R8: While a channel's shadowed period and active time are both 0, its `pwm_o` bit is 1 whatever its polarity and run bits are.
- R9: Writes to the period or active-time register of a running channel do not change its waveform. Clearing and then setting the run bit loads the values written before the cycle in which the bit is set.
- R10: `pwm_oe_o` bit n equals bit n of the output-enable register from the cycle after the write.
- R11: The channels are independent: a write that targets one channel's registers or bits leaves the other channels' waveforms unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PWM input clock; also times the register bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 4 | Channel waveform outputs, bit n for channel n |
| pwm_oe_o | output | 4 | Channel output-enable signals |

## Verification
The hardest condition to reach from the ports is a program-while-running race. New period or active-time values are written during a running waveform, then the run bit is cleared and set again, possibly with further writes in the same cycles. Here the loaded value depends on exactly which edge each write landed on. A directed sequence reprograms a live channel and then restarts it. The random phase then mixes register writes, run-bit toggles and small period values (0 to 13). This makes wrap points, the all-zero idle case and restarts around fresh writes occur many times. Every cycle is compared against a cycle-accurate model built from the requirements.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int NUM_CH = 4;
  localparam int DW     = 32;
  localparam int AW     = 8;

  localparam logic [AW-1:0] POL_ADDR   = 8'h40;
  localparam logic [AW-1:0] RUN_ADDR   = 8'h44;
  localparam logic [AW-1:0] OE_ADDR    = 8'hD0;
  localparam int            CH_STRIDE  = 8;
  localparam int            PER_OFFSET = 4;
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         we_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_CH-1:0][DATA_W-1:0]  act_o,
  output logic [N_CH-1:0][DATA_W-1:0]  per_o,
  output logic [N_CH-1:0]              pol_o,
  output logic [N_CH-1:0]              run_o,
  output logic [N_CH-1:0]              oe_o
);
  localparam int PAD_W = DATA_W - N_CH;

  logic [N_CH-1:0][DATA_W-1:0] act_q, per_q;
  logic [N_CH-1:0]             pol_q, run_q, oe_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch_regs
    localparam logic [ADDR_W-1:0] ACT_A = ADDR_W'(c * CH_STRIDE);
    localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(c * CH_STRIDE + PER_OFFSET);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[c] <= '0;
        per_q[c] <= '0;
      end else if (we_i) begin
        if (addr_i == ACT_A) act_q[c] <= wdata_i;
        if (addr_i == PER_A) per_q[c] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= '0;
      run_q <= '0;
      oe_q  <= '0;
    end else if (we_i) begin
      if (addr_i == POL_ADDR) pol_q <= wdata_i[N_CH-1:0];
      if (addr_i == RUN_ADDR) run_q <= wdata_i[N_CH-1:0];
      if (addr_i == OE_ADDR)  oe_q  <= wdata_i[N_CH-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == ADDR_W'(c * CH_STRIDE))              rdata_o = act_q[c];
      if (addr_i == ADDR_W'(c * CH_STRIDE + PER_OFFSET)) rdata_o = per_q[c];
    end
    if (addr_i == POL_ADDR) rdata_o = {{PAD_W{1'b0}}, pol_q};
    if (addr_i == RUN_ADDR) rdata_o = {{PAD_W{1'b0}}, run_q};
    if (addr_i == OE_ADDR)  rdata_o = {{PAD_W{1'b0}}, oe_q};
  end

  assign act_o = act_q;
  assign per_o = per_q;
  assign pol_o = pol_q;
  assign run_o = run_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
  import qpwm_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pol_i,
  input  logic [DATA_W-1:0] act_i,
  input  logic [DATA_W-1:0] per_i,
  output logic              pwm_o,
  output logic              idle_hi_o
);
  logic [DATA_W-1:0] act_sh_q, per_sh_q, cnt_q;
  logic              wrap;
  logic              lvl;

  // shadows follow programmed values only while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sh_q <= '0;
      per_sh_q <= '0;
    end else if (!run_i) begin
      act_sh_q <= act_i;
      per_sh_q <= per_i;
    end
  end

  assign wrap = (per_sh_q == '0) || (cnt_q >= per_sh_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign idle_hi_o = (act_sh_q == '0) && (per_sh_q == '0);
  assign lvl       = run_i && (cnt_q < act_sh_q);
  assign pwm_o     = idle_hi_o ? 1'b1 : (lvl ^ pol_i);
endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl
  import qpwm_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o,
  output logic [N_CH-1:0]   pwm_oe_o
);
  logic [N_CH-1:0][DATA_W-1:0] act_w, per_w;
  logic [N_CH-1:0]             pol_w, run_w, oe_w, idle_w;

  qpwm_regs #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .act_o   (act_w),
    .per_o   (per_w),
    .pol_o   (pol_w),
    .run_o   (run_w),
    .oe_o    (oe_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    qpwm_chan #(.DATA_W(DATA_W)) chan_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_w[c]),
      .pol_i     (pol_w[c]),
      .act_i     (act_w[c]),
      .per_i     (per_w[c]),
      .pwm_o     (pwm_o[c]),
      .idle_hi_o (idle_w[c])
    );
  end

  assign pwm_oe_o = oe_w;
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk
  import qpwm_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_CH-1:0]   pwm_o,
  input logic [N_CH-1:0]   pwm_oe_o,
  input logic [N_CH-1:0]   run_i,
  input logic [N_CH-1:0]   pol_i,
  input logic [N_CH-1:0]   idle_i
);
  a_r10_oe_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OE_ADDR) |=> (pwm_oe_o == $past(wdata_i[N_CH-1:0])));

  a_r3_unaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == '0));

  a_r3_gap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(8'h48)) |-> (rdata_o == '0));

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=> (addr_i != ADDR_W'(0) || rdata_o == $past(wdata_i)));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_i[c] |-> pwm_o[c]);

    a_r7_stopped_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[c] && !idle_i[c]) |-> (pwm_o[c] == pol_i[c]));

    a_r9_shadow_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && $past(run_i[c])) |-> $stable(idle_i[c]));
  end
endmodule

bind quad_pwm_ctrl qpwm_chk #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pwm_o    (pwm_o),
  .pwm_oe_o (pwm_oe_o),
  .run_i    (run_w),
  .pol_i    (pol_w),
  .idle_i   (idle_w)
);

// File: tb/quad_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_ctrl_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o, pwm_oe_o;

  always #5 clk = ~clk;

  quad_pwm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
  );

  // requirement-level model
  logic [31:0] m_act [NCH];
  logic [31:0] m_per [NCH];
  logic [31:0] s_act [NCH];
  logic [31:0] s_per [NCH];
  logic [31:0] m_k   [NCH];
  logic [3:0]  m_pol, m_run, m_oe;

  int    vec = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a < 8'h20) return a[2] ? m_per[a[4:3]] : m_act[a[4:3]];
    if (a == 8'h40) return {28'd0, m_pol};
    if (a == 8'h44) return {28'd0, m_run};
    if (a == 8'hD0) return {28'd0, m_oe};
    return '0;
  endfunction

  function automatic logic [3:0] exp_pwm();
    logic [3:0] r;
    for (int c = 0; c < NCH; c++) begin
      if (s_act[c] == 0 && s_per[c] == 0) r[c] = 1'b1;                 // R8
      else r[c] = (m_run[c] && (m_k[c] < s_act[c])) ^ m_pol[c];         // R4 R5 R6 R7
    end
    return r;
  endfunction

  task automatic model_edge(input logic we, input logic [7:0] a, input logic [31:0] d);
    for (int c = 0; c < NCH; c++) begin
      if (m_run[c]) m_k[c] = (s_per[c] == 0 || m_k[c] >= s_per[c] - 1) ? 0 : m_k[c] + 1;
      else begin
        m_k[c]   = 0;
        s_act[c] = m_act[c];
        s_per[c] = m_per[c];
      end
    end
    if (we && a[1:0] == 2'b00) begin
      if (a < 8'h20) begin
        if (a[2]) m_per[a[4:3]] = d;
        else      m_act[a[4:3]] = d;
      end
      if (a == 8'h40) m_pol = d[3:0];
      if (a == 8'h44) m_run = d[3:0];
      if (a == 8'hD0) m_oe  = d[3:0];
    end
  endtask

  task automatic check_now();
    logic [3:0]  ep, eo;
    logic [31:0] er;
    ep = exp_pwm();
    eo = m_oe;
    er = exp_rd(addr_i);
    vec++;
    if (pwm_o !== ep || pwm_oe_o !== eo || rdata_o !== er) begin
      bad++;
      $display("FAIL %s addr=%h pwm=%h/%h oe=%h/%h rdata=%h/%h (actual/expected)",
               cur_req, addr_i, pwm_o, ep, pwm_oe_o, eo, rdata_o, er);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d);
    we_i = we; addr_i = a; wdata_i = d;
    #1;
    check_now();
    model_edge(we, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h44, 32'd0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      m_act[c] = 0; m_per[c] = 0; s_act[c] = 0; s_per[c] = 0; m_k[c] = 0;
    end
    m_pol = 0; m_run = 0; m_oe = 0;

    // R1: state during and right after reset
    repeat (3) @(negedge clk);
    #1; check_now();
    rst_ni = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      step(1'b0, 8'(c * 8), 0);
      step(1'b0, 8'(c * 8 + 4), 0);
    end
    step(1'b0, 8'h40, 0); step(1'b0, 8'h44, 0); step(1'b0, 8'hD0, 0);

    // R2: write / readback, shared-register masking
    cur_req = "R2";
    for (int c = 0; c < NCH; c++) begin
      wr(8'(c * 8), 32'hA5A5_0000 | c);
      wr(8'(c * 8 + 4), 32'h5A5A_0000 | c);
    end
    for (int c = 0; c < NCH; c++) begin
      step(1'b0, 8'(c * 8), 0);
      step(1'b0, 8'(c * 8 + 4), 0);
    end
    wr(8'h40, 32'hFFFF_FFF0); step(1'b0, 8'h40, 0);
    wr(8'h40, 32'h0);

    // R3: unmapped reads and writes
    cur_req = "R3";
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    step(1'b0, 8'h48, 0); step(1'b0, 8'h01, 0); step(1'b0, 8'h22, 0);
    step(1'b0, 8'hD4, 0); step(1'b0, 8'hFC, 0); step(1'b0, 8'h00, 0);

    // R4: basic waveform on channel 0, P=5 A=2
    cur_req = "R4";
    wr(8'h00, 2); wr(8'h04, 5); wr(8'h44, 32'h1);
    idle(12);

    // R5: A>=P constant active on ch1, A=0 constant inactive on ch2
    cur_req = "R5";
    wr(8'h08, 7); wr(8'h0C, 4); wr(8'h10, 0); wr(8'h14, 3);
    wr(8'h44, 32'h7);
    idle(8);

    // R6: polarity inversion while running
    cur_req = "R6";
    wr(8'h40, 32'h5); idle(6); wr(8'h40, 32'h0); idle(2);

    // R9: reprogram while running, then restart to load
    cur_req = "R9";
    wr(8'h04, 3); wr(8'h00, 1); idle(8);
    wr(8'h44, 32'h6); wr(8'h44, 32'h7); idle(8);

    // R7: stopped level follows polarity; restart counts from 0
    cur_req = "R7";
    wr(8'h44, 32'h0); wr(8'h40, 32'h3); idle(3);
    wr(8'h44, 32'h1); idle(4); wr(8'h40, 32'h0);

    // R8: all-zero channel stays high across polarity and run
    cur_req = "R8";
    wr(8'h18, 0); wr(8'h1C, 0); wr(8'h44, 32'hF); wr(8'h40, 32'hF);
    idle(4); wr(8'h40, 32'h0); idle(2);

    // R10: output enable
    cur_req = "R10";
    wr(8'hD0, 32'h9); idle(1); wr(8'hD0, 32'hFFFF_FFF6); idle(1);

    // R11: random mix, channels checked independently every cycle
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom % 8);
      if (sel < 4)
        wr(8'(($urandom % 4) * 8 + ($urandom % 2) * 4), $urandom % 14);
      else if (sel == 4) begin
        case ($urandom % 3)
          0: wr(8'h40, $urandom);
          1: wr(8'h44, $urandom);
          default: wr(8'hD0, $urandom);
        endcase
      end else if (sel == 5)
        step(1'b0, 8'($urandom % 256), 0);
      else
        step(1'b0, 8'(($urandom % 4) * 8 + ($urandom % 2) * 4), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule